// File: doc/BRIEF.md
# Clock Fail Detector with Fallback

This block watches two external oscillator clocks, a high-speed one and a low-speed one, from a free-running reference clock. Each oscillator drives a toggle flop in its own domain. The toggle is synchronised into the reference domain, and every change counts as activity. If an oscillator shows no activity for a fixed number of reference cycles, it is declared failed and its status flag is set. Detection can be enabled separately for each source.

The block also holds the system clock select code. When the high-speed oscillator fails while it is the selected system clock, hardware forces the select output to the internal RC oscillator at once, with no software step. That override holds until software writes the select register again. A low-speed failure only sets its flag.

A small register port gives access to a control register, a write-1-to-clear status register and the select register. All writes pass only while the protection-unlock input is high. One interrupt output combines the flags through their interrupt-enable bits. The block has no data stream, so every pin is a plain control or status signal.

Top module: `clk_fail_guard`

## Requirements
- R1: After reset, CTRL (address 0), STATUS (address 1) and the CLKSEL readback (address 2) all read 0, `clk_sel` is 0 (RC) and `irq` is low. Address 3 always reads 0.
- R2: A failed high-speed oscillator sets STATUS bit 0, and a failed low-speed oscillator sets STATUS bit 1. A flag is set only while that source's detect-enable bit is 1: CTRL bit 0 for high-speed, CTRL bit 2 for low-speed.
- R3: A source is declared failed after 16 consecutive reference cycles with no synchronised edge. An oscillator that is still toggling is never flagged, and a flag does not appear within 8 reference cycles of the oscillator stopping.
- R4: A high-speed failure while the effective select is HS (code 1) drives `clk_sel` to RC (code 0) in the same cycle the flag sets. The CLKSEL readback then shows bit 2 = 1 (override) and bits [1:0] = 0.
- R5: A low-speed failure sets only its flag and leaves `clk_sel` unchanged. A high-speed failure while the select is not HS sets its flag but does not set the override.
- R6: The override stays set after the oscillator starts again. It clears only on a write to CLKSEL, which also loads the new code.
- R7: `irq` is high when any flag is set together with its interrupt-enable bit: CTRL bit 1 for high-speed, CTRL bit 3 for low-speed. A flag is still recorded while its interrupt enable is 0.
- R8: Writing 1 to a STATUS bit clears that flag. Writing 0 to a STATUS bit has no effect.
- R9: While `unlock` is low, writes to any register are ignored.
- R10: With a detect-enable bit at 0, a stopped oscillator sets no flag and causes no override.
- R11: The select codes are 0 = RC, 1 = HS and 2 = LS. A write of code 3 is stored as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all registers run on it |
| ref_rst_n | input | 1 | Asynchronous active-low reset |
| hs_osc_clk | input | 1 | High-speed oscillator under watch |
| ls_osc_clk | input | 1 | Low-speed oscillator under watch |
| unlock | input | 1 | Write protection; writes are accepted only while high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 CTRL, 1 STATUS, 2 CLKSEL) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Combinational read data |
| clk_sel | output | 2 | Effective system clock select code |
| irq | output | 1 | Combined fail interrupt |

## Verification
A register write takes effect at the reference edge where it is presented, so the bench drives writes on falling edges and reads them back at the next falling edge. A fail flag, the `clk_sel` override and `irq` all change at the same reference edge. That edge comes 16 quiet cycles after the last synchronised edge, so 16 to about 20 cycles after the oscillator stops, counting synchroniser latency. The bench therefore checks that nothing is flagged 8 cycles after a stop and that everything has updated 38 cycles after it. Checks for "no effect" are made after the same 38-cycle wait.

// File: rtl/cfd_pkg.sv
package cfd_pkg;
  localparam int NUM_SRC = 2;
  localparam int SRC_HS  = 0;
  localparam int SRC_LS  = 1;
  localparam int ADDR_W  = 2;
  localparam int DATA_W  = 8;
  localparam int CTRL_W  = 2 * NUM_SRC;

  typedef enum logic [1:0] {
    SEL_RC  = 2'd0,
    SEL_HS  = 2'd1,
    SEL_LS  = 2'd2,
    SEL_RSV = 2'd3
  } sel_e;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_SEL  = 2'd2;
endpackage

// File: rtl/cfd_edge_sense.sv
module cfd_edge_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic osc_clk,
  input  logic ref_clk,
  input  logic rst_n,
  output logic act
);
  logic tog;
  logic [SYNC_STAGES:0] shreg;

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) tog <= 1'b0;
    else        tog <= ~tog;
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[SYNC_STAGES-1:0], tog};
  end

  assign act = shreg[SYNC_STAGES] ^ shreg[SYNC_STAGES-1];
endmodule

// File: rtl/cfd_stall_timer.sv
module cfd_stall_timer #(
  parameter int TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic act,
  output logic stall_evt
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LIM  = CW'(TIMEOUT);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt;

  // pulse on the last quiet cycle; the counter then saturates so it fires once
  assign stall_evt = en && !act && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!en || act) cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cfd_regs.sv
module cfd_regs
  import cfd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                unlock,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [NUM_SRC-1:0]  stall_evt,
  output logic [DATA_W-1:0]   rd_data,
  output logic [CTRL_W-1:0]   ctrl_q,
  output logic [NUM_SRC-1:0]  flag_q,
  output logic                ovr_q,
  output logic [NUM_SRC-1:0]  det_en,
  output logic [1:0]          clk_sel,
  output logic                irq
);
  logic wr_ok;
  sel_e sw_sel_q;
  logic [NUM_SRC-1:0] ie;
  logic [NUM_SRC-1:0] hit;

  assign wr_ok = wr_en && unlock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        ctrl_q <= '0;
    else if (wr_ok && wr_addr == A_CTRL) ctrl_q <= wr_data[CTRL_W-1:0];
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic clr;
    assign det_en[i] = ctrl_q[2*i];
    assign ie[i]     = ctrl_q[2*i+1];
    assign clr       = wr_ok && (wr_addr == A_STAT) && wr_data[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            flag_q[i] <= 1'b0;
      else if (stall_evt[i]) flag_q[i] <= 1'b1;
      else if (clr)          flag_q[i] <= 1'b0;
    end
    assign hit[i] = flag_q[i] & ie[i];
  end

  assign irq = |hit;

  logic sel_wr;
  logic fall_set;
  assign sel_wr   = wr_ok && (wr_addr == A_SEL);
  assign fall_set = stall_evt[SRC_HS] && (sw_sel_q == SEL_HS) && !ovr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_sel_q <= SEL_RC;
    end else if (sel_wr) begin
      sw_sel_q <= (wr_data[1:0] == SEL_RSV) ? SEL_RC : sel_e'(wr_data[1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovr_q <= 1'b0;
    else if (fall_set) ovr_q <= 1'b1;
    else if (sel_wr)   ovr_q <= 1'b0;
  end

  assign clk_sel = ovr_q ? SEL_RC : sw_sel_q;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL:  rd_data[CTRL_W-1:0]  = ctrl_q;
      A_STAT:  rd_data[NUM_SRC-1:0] = flag_q;
      A_SEL:   rd_data[2:0]         = {ovr_q, clk_sel};
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/clk_fail_guard.sv
module clk_fail_guard
  import cfd_pkg::*;
#(
  parameter int TIMEOUT     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              ref_clk,
  input  logic              ref_rst_n,
  input  logic              hs_osc_clk,
  input  logic              ls_osc_clk,
  input  logic              unlock,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        clk_sel,
  output logic              irq
);
  logic [NUM_SRC-1:0] osc;
  logic [NUM_SRC-1:0] act;
  logic [NUM_SRC-1:0] stall_evt;
  logic [NUM_SRC-1:0] det_en;
  logic [CTRL_W-1:0]  ctrl_q;
  logic [NUM_SRC-1:0] flag_q;
  logic               ovr_q;

  assign osc[SRC_HS] = hs_osc_clk;
  assign osc[SRC_LS] = ls_osc_clk;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_mon
    cfd_edge_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
      .osc_clk (osc[i]),
      .ref_clk (ref_clk),
      .rst_n   (ref_rst_n),
      .act     (act[i])
    );
    cfd_stall_timer #(.TIMEOUT(TIMEOUT)) u_timer (
      .clk       (ref_clk),
      .rst_n     (ref_rst_n),
      .en        (det_en[i]),
      .act       (act[i]),
      .stall_evt (stall_evt[i])
    );
  end

  cfd_regs u_regs (
    .clk       (ref_clk),
    .rst_n     (ref_rst_n),
    .unlock    (unlock),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .stall_evt (stall_evt),
    .rd_data   (rd_data),
    .ctrl_q    (ctrl_q),
    .flag_q    (flag_q),
    .ovr_q     (ovr_q),
    .det_en    (det_en),
    .clk_sel   (clk_sel),
    .irq       (irq)
  );
endmodule

// File: rtl/clk_fail_guard_chk.sv
module clk_fail_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       unlock,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic [3:0] ctrl,
  input logic [1:0] flags,
  input logic       ovr,
  input logic [1:0] clk_sel,
  input logic       irq
);
  AST_CTRL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !unlock) |=> $stable(ctrl)); // R9
  AST_FALLBACK_RC: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |-> (clk_sel == 2'd0)); // R4
  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !(wr_en && unlock && wr_addr == 2'd2)) |=> ovr); // R6
  AST_HS_FLAG_NEEDS_DET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> $past(ctrl[0])); // R2
  AST_LS_FLAG_NEEDS_DET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[1]) |-> $past(ctrl[2])); // R10
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[1] && !ctrl[3]) |-> !irq); // R7
endmodule

bind clk_fail_guard clk_fail_guard_chk u_chk (
  .clk     (ref_clk),
  .rst_n   (ref_rst_n),
  .unlock  (unlock),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .ctrl    (ctrl_q),
  .flags   (flag_q),
  .ovr     (ovr_q),
  .clk_sel (clk_sel),
  .irq     (irq)
);

// File: tb/clk_fail_guard_tb.sv
module clk_fail_guard_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hs_clk = 1'b0, ls_clk = 1'b0;
  logic       hs_run = 1'b1, ls_run = 1'b1;
  logic       unlock = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [1:0] clk_sel;
  logic       irq;
  int nchk = 0, nerr = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;
  always begin #3;  if (hs_run) hs_clk = ~hs_clk; end
  always begin #10; if (ls_run) ls_clk = ~ls_clk; end

  clk_fail_guard u_dut (
    .ref_clk(clk), .ref_rst_n(rst_n), .hs_osc_clk(hs_clk), .ls_osc_clk(ls_clk),
    .unlock(unlock), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .clk_sel(clk_sel), .irq(irq)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic wait_ref(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(2'd0, d); chk("R1", "ctrl after reset", d, 0);
    rd(2'd1, d); chk("R1", "status after reset", d, 0);
    rd(2'd2, d); chk("R1", "clksel after reset", d, 0);
    rd(2'd3, d); chk("R1", "unused address", d, 0);
    chk("R1", "clk_sel after reset", clk_sel, 0);
    chk("R1", "irq after reset", irq, 0);
  endtask

  task automatic t_lock;
    logic [7:0] d;
    unlock = 1'b0;
    wr(2'd0, 8'h0F); wr(2'd2, 8'h01);
    rd(2'd0, d); chk("R9", "ctrl written while locked", d, 0);
    rd(2'd2, d); chk("R9", "clksel written while locked", d, 0);
    unlock = 1'b1;
  endtask

  task automatic t_hs_fallback;
    logic [7:0] d;
    wr(2'd0, 8'h03); wr(2'd2, 8'h01);
    chk("R11", "clk_sel HS code", clk_sel, 1);
    wait_ref(40);
    rd(2'd1, d); chk("R3", "no flag while running", d, 0);
    hs_run = 1'b0;
    wait_ref(8);
    rd(2'd1, d); chk("R3", "no flag 8 cycles after stop", d, 0);
    chk("R3", "select held before timeout", clk_sel, 1);
    wait_ref(30);
    rd(2'd1, d); chk("R2", "hs flag set", d, 8'h01);
    chk("R4", "clk_sel forced to RC", clk_sel, 0);
    rd(2'd2, d); chk("R4", "clksel readback override", d, 8'h04);
    chk("R7", "irq with hs enable", irq, 1);
    hs_run = 1'b1;
    wait_ref(40);
    chk("R6", "override held after recovery", clk_sel, 0);
    wr(2'd1, 8'h00);
    rd(2'd1, d); chk("R8", "write 0 keeps flag", d, 8'h01);
    wr(2'd1, 8'h01);
    rd(2'd1, d); chk("R8", "write 1 clears flag", d, 0);
    chk("R7", "irq drops after clear", irq, 0);
    wr(2'd2, 8'h01);
    rd(2'd2, d); chk("R6", "rewrite clears override", d, 8'h01);
  endtask

  task automatic t_ls_only;
    logic [7:0] d;
    wr(2'd0, 8'h04);
    ls_run = 1'b0;
    wait_ref(38);
    rd(2'd1, d); chk("R2", "ls flag set", d, 8'h02);
    chk("R7", "irq low with ls enable off", irq, 0);
    chk("R5", "ls failure leaves select", clk_sel, 1);
    wr(2'd0, 8'h0C);
    chk("R7", "irq after ls enable set", irq, 1);
    wr(2'd1, 8'h02);
    ls_run = 1'b1;
    wait_ref(20);
  endtask

  task automatic t_det_off;
    logic [7:0] d;
    wr(2'd0, 8'h00);
    hs_run = 1'b0;
    wait_ref(38);
    rd(2'd1, d); chk("R10", "no flag with detect off", d, 0);
    chk("R10", "no override with detect off", clk_sel, 1);
    hs_run = 1'b1;
    wait_ref(20);
  endtask

  task automatic t_hs_not_selected;
    logic [7:0] d;
    wr(2'd0, 8'h01); wr(2'd2, 8'h02);
    hs_run = 1'b0;
    wait_ref(38);
    rd(2'd1, d); chk("R5", "hs flag with LS selected", d, 8'h01);
    rd(2'd2, d); chk("R5", "no override when HS not selected", d, 8'h02);
    wr(2'd1, 8'h01);
    hs_run = 1'b1;
    wait_ref(20);
  endtask

  task automatic t_sel_code;
    logic [7:0] d;
    wr(2'd2, 8'h03);
    rd(2'd2, d); chk("R11", "code 3 stored as RC", d, 0);
    chk("R11", "clk_sel for code 3", clk_sel, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lock();
    t_hs_fallback();
    t_ls_only();
    t_det_off();
    t_hs_not_selected();
    t_sel_code();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule